// File: doc/BRIEF.md
# SMRAM Window Access Controller

The block steers every access that lands in the legacy graphics window (0xA0000 to 0xBFFFF) either to system DRAM, where the protected SMRAM lives, or to the PCI bus. Each request carries a flag from the processor telling whether it was issued in system management mode. A three-bit control register sets the policy. It has an open bit, a close bit and a lock bit. Setting the lock bit keeps the window hidden from ordinary traffic until the next reset.

The decision is made for each request on its own. Two requesters, one in management mode and one not, can therefore reach different targets through the same address in back-to-back cycles. Requests outside the window are not claimed. The route result is registered and appears one cycle after the request. The control register can be read back at all times. A sticky error flag records any write that requested open and close together.

Top module: `smram_window_ctl`

## Requirements
- R1: While reset is asserted and just after it is released, cfg_value is 0 (open, close and lock all clear), cfg_err is 0, and route_valid, route_hit, route_dram and route_write are 0.
- R2: A valid request inside the window, without the management-mode flag and with the open bit clear, gives route_hit=1 and route_dram=0, which means PCI. This holds for reads and writes alike.
- R3: A valid request inside the window with the management-mode flag set and the close bit clear gives route_hit=1 and route_dram=1, which means DRAM.
- R4: When the open bit (cfg bit 0) is 1 and the lock bit (cfg bit 2) is 0, a window request without the management-mode flag goes to DRAM.
- R5: A write that sets the lock bit clears the open bit in the same write. From then on, writes to the open bit are ignored: cfg_value bit 0 reads 0 and non-mode window requests go to PCI.
- R6: Once set, the lock bit stays 1 through any register write. Only reset clears it.
- R7: While the close bit (cfg bit 1) is 1, window requests carrying the management-mode flag go to PCI.
- R8: Requests outside 0xA0000 to 0xBFFFF give route_hit=0 and route_dram=0. Both ends of the window are inside it; 0x9FFFF and 0xC0000 are outside.
- R9: A register write whose data has bit 0 and bit 1 both set raises cfg_err. The flag stays at 1 until reset.
- R10: The target follows the flag of each request on its own. Alternating flagged and unflagged requests to one address alternate between DRAM and PCI when the open bit is clear and the close bit is clear.
- R11: Route outputs are valid on the first rising edge after the request. A register write becomes visible in cfg_value after its edge. A request presented on the same edge as a write is routed under the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_smm | input | 1 | Request issued in system management mode |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 3 | Write data: bit 0 open, bit 1 close, bit 2 lock |
| route_valid | output | 1 | Registered copy of req_valid |
| route_hit | output | 1 | Request fell inside the window |
| route_dram | output | 1 | 1 routes to DRAM, 0 routes to PCI |
| route_write | output | 1 | Registered direction of a valid request |
| cfg_value | output | 3 | Current control register value |
| cfg_err | output | 1 | Sticky flag for an open-and-close write |

## Verification
Route results are due one rising edge after a request, and register readback is due one edge after a write. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, so every sample comes after exactly one register stage. Vectors that write the register and present a request together check that the routing uses the value from before the write. The first request on the following cycle then shows the new value taking effect.

// File: rtl/smram_pkg.sv
package smram_pkg;

  localparam int CFG_W        = 3;
  localparam int CFG_OPEN_BIT  = 0;
  localparam int CFG_CLOSE_BIT = 1;
  localparam int CFG_LOCK_BIT  = 2;

  // Field order matches the register bit positions (lock is the MSB).
  typedef struct packed {
    logic lock;
    logic close;
    logic open;
  } smram_cfg_t;

endpackage

// File: rtl/smram_win_decode.sv
module smram_win_decode #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 32'h000B_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);

  logic above_base;
  logic below_last;

  always_comb begin
    above_base = (addr >= WIN_BASE);
    below_last = (addr <= WIN_LAST);
    in_win     = above_base && below_last;
  end

endmodule

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  smram_cfg_t wr_data,
  output smram_cfg_t cfg_q,
  output logic       err_q
);

  smram_cfg_t cfg_d;
  logic       err_d;

  // Next-state: the lock bit is sticky, and lock holds open at zero.
  always_comb begin
    cfg_d.lock  = cfg_q.lock | wr_data.lock;
    cfg_d.close = wr_data.close;
    cfg_d.open  = wr_data.open & ~cfg_d.lock;
    err_d       = err_q | (wr_data.open & wr_data.close);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_smm,
  input  logic       in_win,
  input  smram_cfg_t cfg,
  output logic       route_valid,
  output logic       route_hit,
  output logic       route_dram,
  output logic       route_write
);

  logic valid_d;
  logic hit_d;
  logic dram_sel;
  logic dram_d;
  logic write_d;

  always_comb begin
    valid_d  = req_valid;
    hit_d    = req_valid & in_win;
    // Mode-flagged traffic sees SMRAM unless closed; other traffic only when open and unlocked.
    dram_sel = req_smm ? ~cfg.close : (cfg.open & ~cfg.lock);
    dram_d   = hit_d & dram_sel;
    write_d  = req_valid & req_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_valid <= 1'b0;
      route_hit   <= 1'b0;
      route_dram  <= 1'b0;
      route_write <= 1'b0;
    end else begin
      route_valid <= valid_d;
      route_hit   <= hit_d;
      route_dram  <= dram_d;
      route_write <= write_d;
    end
  end

endmodule

// File: rtl/smram_window_ctl.sv
module smram_window_ctl
  import smram_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 32'h000B_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_smm,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic              route_valid,
  output logic              route_hit,
  output logic              route_dram,
  output logic              route_write,
  output logic [CFG_W-1:0]  cfg_value,
  output logic              cfg_err
);

  logic       in_win;
  smram_cfg_t cfg_q;

  smram_win_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WIN_LAST(WIN_LAST)
  ) u_decode (
    .addr  (req_addr),
    .in_win(in_win)
  );

  smram_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .wr_data(smram_cfg_t'(cfg_wr_data)),
    .cfg_q  (cfg_q),
    .err_q  (cfg_err)
  );

  smram_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_smm    (req_smm),
    .in_win     (in_win),
    .cfg        (cfg_q),
    .route_valid(route_valid),
    .route_hit  (route_hit),
    .route_dram (route_dram),
    .route_write(route_write)
  );

  assign cfg_value = cfg_q;

endmodule

// File: rtl/smram_window_chk.sv
module smram_window_chk
  import smram_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 32'h000B_FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_smm,
  input logic              route_valid,
  input logic              route_hit,
  input logic              route_dram,
  input logic [CFG_W-1:0]  cfg_value,
  input logic              cfg_err
);

  logic win_req;
  assign win_req = req_valid && (req_addr >= WIN_BASE) && (req_addr <= WIN_LAST);

  AST_SMM_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (win_req && req_smm && !cfg_value[CFG_CLOSE_BIT]) |=> route_dram); // R3
  AST_PLAIN_TO_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    (win_req && !req_smm && !cfg_value[CFG_OPEN_BIT]) |=> (route_hit && !route_dram)); // R2
  AST_OPEN_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (win_req && !req_smm && cfg_value[CFG_OPEN_BIT] && !cfg_value[CFG_LOCK_BIT]) |=> route_dram); // R4
  AST_LOCK_HIDES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_value[CFG_LOCK_BIT] |-> !cfg_value[CFG_OPEN_BIT]); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_value[CFG_LOCK_BIT]) |-> cfg_value[CFG_LOCK_BIT]); // R6
  AST_CLOSE_TO_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    (win_req && req_smm && cfg_value[CFG_CLOSE_BIT]) |=> !route_dram); // R7
  AST_OUTSIDE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_req |=> (!route_hit && !route_dram)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> cfg_err); // R9
  AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    route_hit |-> route_valid); // R11

endmodule

bind smram_window_ctl smram_window_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_BASE(WIN_BASE),
  .WIN_LAST(WIN_LAST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_smm    (req_smm),
  .route_valid(route_valid),
  .route_hit  (route_hit),
  .route_dram (route_dram),
  .cfg_value  (cfg_value),
  .cfg_err    (cfg_err)
);

// File: tb/smram_window_ctl_bench.sv
`timescale 1ns/1ps
module smram_window_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic        req_smm;
  logic        cfg_wr_en;
  logic [2:0]  cfg_wr_data;
  logic        route_valid;
  logic        route_hit;
  logic        route_dram;
  logic        route_write;
  logic [2:0]  cfg_value;
  logic        cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  smram_window_ctl u_smram_window_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_smm(req_smm), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_data(cfg_wr_data), .route_valid(route_valid), .route_hit(route_hit),
    .route_dram(route_dram), .route_write(route_write), .cfg_value(cfg_value),
    .cfg_err(cfg_err)
  );

  // Vector: [47] we, [46:44] cfg data, [43] valid, [42] smm, [41] write,
  //         [40] expected hit, [39] expected dram, [31:0] address.
  localparam int NV = 19;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0,3'b000,1'b1,1'b0,1'b0,1'b1,1'b0,7'd0,32'h000A_0000}, // R2 read, low edge
    {1'b0,3'b000,1'b1,1'b0,1'b1,1'b1,1'b0,7'd0,32'h000B_FFFF}, // R2 write, high edge
    {1'b0,3'b000,1'b1,1'b1,1'b0,1'b1,1'b1,7'd0,32'h000A_0000}, // R3
    {1'b0,3'b000,1'b1,1'b1,1'b0,1'b0,1'b0,7'd0,32'h0009_FFFF}, // R8 below
    {1'b0,3'b000,1'b1,1'b1,1'b0,1'b0,1'b0,7'd0,32'h000C_0000}, // R8 above
    {1'b1,3'b001,1'b0,1'b0,1'b0,1'b0,1'b0,7'd0,32'h0000_0000}, // set open
    {1'b0,3'b000,1'b1,1'b0,1'b0,1'b1,1'b1,7'd0,32'h000B_0000}, // R4
    {1'b0,3'b000,1'b1,1'b1,1'b0,1'b1,1'b1,7'd0,32'h000B_0000}, // R3 with open
    {1'b1,3'b010,1'b0,1'b0,1'b0,1'b0,1'b0,7'd0,32'h0000_0000}, // close only
    {1'b0,3'b000,1'b1,1'b1,1'b0,1'b1,1'b0,7'd0,32'h000A_8000}, // R7
    {1'b0,3'b000,1'b1,1'b0,1'b0,1'b1,1'b0,7'd0,32'h000A_8000}, // R2 under close
    {1'b1,3'b011,1'b0,1'b0,1'b0,1'b0,1'b0,7'd0,32'h0000_0000}, // open+close: R9
    {1'b0,3'b000,1'b1,1'b0,1'b0,1'b1,1'b1,7'd0,32'h000A_8000}, // R4
    {1'b0,3'b000,1'b1,1'b1,1'b0,1'b1,1'b0,7'd0,32'h000A_8000}, // R7
    {1'b1,3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,7'd0,32'h0000_0000}, // clear
    {1'b0,3'b000,1'b1,1'b1,1'b0,1'b1,1'b1,7'd0,32'h000A_4000}, // R10 flagged
    {1'b0,3'b000,1'b1,1'b0,1'b0,1'b1,1'b0,7'd0,32'h000A_4000}, // R10 plain
    {1'b1,3'b001,1'b1,1'b0,1'b0,1'b1,1'b0,7'd0,32'h000A_4000}, // R11 old value used
    {1'b0,3'b000,1'b1,1'b0,1'b0,1'b1,1'b1,7'd0,32'h000A_4000}  // R11 new value used
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_smm = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  // Drive on the falling edge, result due after the next rising edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] d);
    idle();
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    step();
    idle();
  endtask

  task automatic request(input logic [31:0] a, input logic smm);
    idle();
    req_valid = 1'b1; req_addr = a; req_smm = smm;
    step();
    idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check("R1 cfg in reset", {29'd0, cfg_value}, 32'd0);
    check("R1 route in reset", {28'd0, route_valid, route_hit, route_dram, route_write}, 32'd0);
    rst_n = 1'b1;
    step();
    check("R1 cfg after reset", {28'd0, cfg_err, cfg_value}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      cfg_wr_en   = VEC[i][47];
      cfg_wr_data = VEC[i][46:44];
      req_valid   = VEC[i][43];
      req_smm     = VEC[i][42];
      req_write   = VEC[i][41];
      req_addr    = VEC[i][31:0];
      step();
      check($sformatf("vector %0d hit (R2/R3/R4/R7/R8/R10/R11)", i), {31'd0, route_hit}, {31'd0, VEC[i][40]});
      check($sformatf("vector %0d dram (R2/R3/R4/R7/R8/R10/R11)", i), {31'd0, route_dram}, {31'd0, VEC[i][39]});
      check($sformatf("vector %0d valid R11", i), {30'd0, route_valid, route_write},
            {30'd0, VEC[i][43], VEC[i][43] & VEC[i][41]});
    end
    idle();
    check("R11 readback after write", {29'd0, cfg_value}, 32'd1);
    check("R9 error flag sticky", {31'd0, cfg_err}, 32'd1);

    // R5: lock together with open leaves open clear.
    cfg_write(3'b101);
    check("R5 lock forces open low", {29'd0, cfg_value}, 32'd4);
    request(32'h000A_0000, 1'b0);
    check("R5 plain request to PCI when locked", {30'd0, route_hit, route_dram}, 32'd2);
    cfg_write(3'b001);
    check("R5 open ignored when locked", {29'd0, cfg_value}, 32'd4);
    cfg_write(3'b000);
    check("R6 lock survives clearing write", {29'd0, cfg_value}, 32'd4);
    request(32'h000B_FFFF, 1'b1);
    check("R3 flagged request to DRAM when locked", {30'd0, route_hit, route_dram}, 32'd3);
    cfg_write(3'b010);
    check("R6 close writable under lock", {29'd0, cfg_value}, 32'd6);
    request(32'h000B_FFFF, 1'b1);
    check("R7 close under lock", {30'd0, route_hit, route_dram}, 32'd2);

    // R1/R6/R9: reset clears lock and error.
    rst_n = 1'b0;
    step();
    check("R1 cfg cleared by reset", {28'd0, cfg_err, cfg_value}, 32'd0);
    rst_n = 1'b1;
    step();
    cfg_write(3'b001);
    check("R6 open settable after reset", {29'd0, cfg_value}, 32'd1);
    request(32'h000A_0000, 1'b0);
    check("R4 open after reset", {30'd0, route_hit, route_dram}, 32'd3);

    done = 1'b1;
    summary();
  end

endmodule